// File: doc/BRIEF.md
# Rate-3/4 Convolutional Encoder with Serial Framing

This block encodes a serial information stream with a convolutional code of three inputs, four outputs and memory order two. Incoming bits are gathered three at a time into an input block, one bit per lane. For each completed block, four parity-style outputs are formed from the current lane bits and a short history of earlier lane bits. The four results leave as a serial burst, one bit per clock.

A frame ends when the bit marked with the end-of-frame input is accepted. If that bit does not complete a block, the block is filled with zeros. Two all-zero blocks then follow automatically, which flushes the history back to zero. The output end-of-frame marker flags the very last output bit. While any output bits are being sent, the input is held off by dropping the ready signal.

Top module: `conv34_enc`

## Requirements
- R1: After reset, out_valid and out_last are low, in_ready is high and all history bits are zero.
- R2: Accepted input bits (in_valid and in_ready both high at a clock edge) fill lane 1, lane 2 and lane 3 of a block in that order. The test blocks 110, 011, 101 (lane 1 first) give the output blocks 1010, 0000, 1110, 0111, 0011, with output 1 written first.
- R3: Output 1 of a block equals the block's lane-1 bit.
- R4: Output 2 equals lane1 XOR lane2 XOR the lane-2 bit of the previous block XOR the lane-3 bit of the previous block.
- R5: Output 3 equals lane1 XOR lane3 XOR the lane-2 bit of the previous block XOR the lane-3 bit from two blocks earlier.
- R6: Output 4 equals lane1 XOR lane2 XOR lane3 XOR the lane-3 bit from two blocks earlier.
- R7: The four output bits of a block leave in the order output 1, 2, 3, 4, with out_valid high on four consecutive cycles. The first bit is valid in the cycle after the edge that accepted the block's last input bit.
- R8: If in_last is accepted on lane 1 or lane 2, the missing lanes of that block are taken as zero.
- R9: After the final block of a frame, two all-zero input blocks are encoded. A frame of L blocks therefore yields exactly 4(L+2) output bits, sent with no gap from the final block on.
- R10: out_last is high on the last bit of the second tail block only. The stream is then idle on the following cycle.
- R11: in_ready is low whenever out_valid is high. Input offered while in_ready is low is not taken.
- R12: After the tail blocks, the history is zero again, so an identical following frame produces identical output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit offered |
| in_data | input | 1 | Serial information bit |
| in_last | input | 1 | Offered bit is the final bit of the frame |
| in_ready | output | 1 | Encoder can accept an input bit |
| out_valid | output | 1 | out_data carries a code bit |
| out_data | output | 1 | Serial code bit |
| out_last | output | 1 | Final code bit of the frame |

## Verification
A wrong history bit shows up in output 2 or 3 of the very next block, or in output 3 or 4 of the block after that. It then stays visible until the tail blocks clear it, so each frame is compared bit for bit against a convolution computed in the bench from the generator table. A lane-order or padding fault corrupts the first burst after the faulty block. A tail count error changes the output bit count and moves out_last, both of which are checked per frame. Encoding two identical frames back to back exposes any history that the tail fails to clear.

// File: rtl/conv34_enc.sv
module conv34_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_data,
  input  logic in_last,
  output logic in_ready,
  output logic out_valid,
  output logic out_data,
  output logic out_last
);
  localparam int NOUT  = 4;
  localparam int TAILB = 2;
  localparam int CW    = $clog2(NOUT);
  localparam int TW    = $clog2(TAILB + 1);

  logic [1:0]      fill;
  logic            b1, b2;
  logic            h2, h3, h3b;
  logic            busy, in_tail;
  logic [NOUT-1:0] sreg;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tail_left;

  logic accept, close, block_done, load, a1, a2, a3;
  logic [NOUT-1:0] blk;

  assign accept     = in_valid & in_ready;
  assign close      = accept & ((fill == 2'd2) | in_last);
  assign block_done = busy & (cnt == CW'(NOUT - 1));
  assign load       = close | (block_done & (tail_left != '0));

  assign a1 = busy ? 1'b0 : ((fill == 2'd0) ? in_data : b1);
  assign a2 = busy ? 1'b0 : ((fill == 2'd2) ? b2 : ((fill == 2'd1) ? in_data : 1'b0));
  assign a3 = busy ? 1'b0 : ((fill == 2'd2) ? in_data : 1'b0);

  assign blk = {a1, a1 ^ a2 ^ h2 ^ h3, a1 ^ h2 ^ a3 ^ h3b, a1 ^ a2 ^ a3 ^ h3b};

  assign in_ready  = ~busy;
  assign out_valid = busy;
  assign out_data  = sreg[NOUT-1];
  assign out_last  = block_done & in_tail & (tail_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= '0;
      b1        <= 1'b0;
      b2        <= 1'b0;
      h2        <= 1'b0;
      h3        <= 1'b0;
      h3b       <= 1'b0;
      busy      <= 1'b0;
      in_tail   <= 1'b0;
      sreg      <= '0;
      cnt       <= '0;
      tail_left <= '0;
    end else begin
      if (accept && !close) begin
        fill <= fill + 2'd1;
        if (fill == 2'd0) b1 <= in_data;
        else              b2 <= in_data;
      end
      if (load) begin
        sreg <= blk;
        h2   <= a2;
        h3   <= a3;
        h3b  <= h3;
        busy <= 1'b1;
        cnt  <= '0;
        if (close) begin
          fill      <= '0;
          tail_left <= in_last ? TW'(TAILB) : '0;
          in_tail   <= 1'b0;
        end else begin
          tail_left <= tail_left - TW'(1);
          in_tail   <= 1'b1;
        end
      end else if (busy) begin
        sreg <= sreg << 1;
        cnt  <= cnt + CW'(1);
        if (block_done) begin
          busy    <= 1'b0;
          in_tail <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/conv34_enc_chk.sv
module conv34_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_last,
  input logic in_ready,
  input logic out_valid,
  input logic out_last
);
  logic [1:0] bitpos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bitpos <= '0;
    else if (out_valid) bitpos <= bitpos + 2'd1;
  end

  p_ready_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_last_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (bitpos == 2'd3));

  p_frame_end_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> out_valid);

  p_burst_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bitpos != 2'd3) |=> out_valid);
endmodule

bind conv34_enc conv34_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_conv34_enc.sv
module sim_conv34_enc;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_data = 0, in_last = 0;
  logic in_ready, out_valid, out_data, out_last;

  int checks = 0, fails = 0;
  int ocnt = 0, ready_viol = 0;
  logic fin  [0:63];
  logic expv [0:511];
  logic obits[0:511];
  logic olast[0:511];

  conv34_enc u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (out_valid) begin
      obits[ocnt] = out_data;
      olast[ocnt] = out_last;
      ocnt = ocnt + 1;
      if (in_ready) ready_viol = ready_viol + 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp_v);
    checks = checks + 1;
    if (act != exp_v) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic logic [2:0] gseq(input int i, input int j);
    case (i)
      0: gseq = 3'b100;
      1: case (j) 0: gseq = 3'b000; 1: gseq = 3'b110; 2: gseq = 3'b010; default: gseq = 3'b100; endcase
      default: case (j) 0: gseq = 3'b000; 1: gseq = 3'b010; default: gseq = 3'b101; endcase
    endcase
  endfunction

  function automatic string jtag(input int j);
    case (j) 0: jtag = "R3"; 1: jtag = "R4"; 2: jtag = "R5"; default: jtag = "R6"; endcase
  endfunction

  function automatic int build_expected(input int nb);
    int nblk;
    nblk = (nb + 2) / 3;
    for (int b = 0; b < nblk + 2; b++)
      for (int j = 0; j < 4; j++) begin
        logic v;
        v = 1'b0;
        for (int i = 0; i < 3; i++)
          for (int r = 0; r < 3; r++)
            if (b - r >= 0 && b - r < nblk) begin
              int idx;
              logic [2:0] g;
              idx = 3 * (b - r) + i;
              g = gseq(i, j);
              v ^= g[2 - r] & ((idx < nb) ? fin[idx] : 1'b0);
            end
        expv[4*b + j] = v;
      end
    return 4 * (nblk + 2);
  endfunction

  task automatic run_frame(input int nb, input string name);
    int expn, w;
    expn = build_expected(nb);
    ocnt = 0;
    ready_viol = 0;
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = fin[k]; in_last = (k == nb - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (k % 3 == 2 || k == nb - 1) begin
        @(negedge clk);
        check({"R7 first bit valid ", name}, out_valid, 1);
        check({"R7 first bit value ", name}, out_data, expv[4*(k/3)]);
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_data = 0;
    w = 0;
    while ((ocnt < expn || out_valid) && w < 300) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    check({"R9 bit count ", name}, ocnt, expn);
    for (int x = 0; x < expn; x++) begin
      check({jtag(x % 4), " bit ", name}, obits[x], expv[x]);
      check({"R10 last flag ", name}, olast[x], (x == expn - 1));
    end
    check({"R11 ready low while sending ", name}, ready_viol, 0);
    check({"R10 idle after frame ", name}, out_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 out_last", out_last, 0);
  endtask

  task automatic t_vector();
    logic [19:0] golden;
    golden = 20'b1010_0000_1110_0111_0011;
    {fin[0], fin[1], fin[2]} = 3'b110;
    {fin[3], fin[4], fin[5]} = 3'b011;
    {fin[6], fin[7], fin[8]} = 3'b101;
    run_frame(9, "vector");
    for (int x = 0; x < 20; x++) check("R2 test vector", obits[x], golden[19 - x]);
  endtask

  task automatic t_pad();
    {fin[0], fin[1], fin[2], fin[3]} = 4'b1011;
    run_frame(4, "R8 pad two");
    {fin[0], fin[1], fin[2], fin[3], fin[4]} = 5'b01111;
    run_frame(5, "R8 pad one");
    fin[0] = 1'b1;
    run_frame(1, "R8 single bit");
  endtask

  task automatic t_repeat();
    for (int k = 0; k < 12; k++) fin[k] = logic'((k * 7 + 3) % 5 > 1);
    run_frame(12, "R12 first");
    run_frame(12, "R12 second");
    for (int k = 0; k < 30; k++) fin[k] = logic'(((k * 13) ^ (k >> 1)) & 1);
    run_frame(30, "long");
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_pad();
    t_repeat();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule